// File: doc/BRIEF.md
# GPU Command List Parser

This block walks a buffer of 32-bit words that holds GPU register-write commands and turns it into a series of internal register writes. Each write carries a 16-bit register id, a 32-bit data value and a 32-bit byte-enable mask. Words arrive on a valid/ready stream. Writes leave on a valid/ready port. A start pulse supplies the buffer length, counted in 8-byte units, and two descriptor words whose only use is to be latched as flags.

A command always starts on an even word index. Its first word is the first data value and its second word is a header. The header gives the target id, a 4-bit byte-enable index, a count of extra data words and a bit that picks incrementing or fixed ids. One odd word between commands is skipped as padding. The parser stops at the buffer end. If the buffer ends inside a command, it stops and reports the truncation.

Top module: `cmdlist_parser`

## Requirements
- R1: After reset, `wr_valid`, `word_ready`, `busy`, `trunc_err`, `gas_update` and `flush_req` are all 0.
- R2: Each command's first write targets header bits [15:0] and carries the word that came before the header.
- R3: Header bits [19:16] expand to the mask. Index bit n set makes mask byte n 8'hFF, and clear makes it 8'h00. For example, 4'b1001 gives 32'hFF0000FF. Every write of one command uses the same mask.
- R4: Header bits [27:20] give N, the number of extra data words. The command then makes N+1 writes, with data in buffer order.
- R5: When header bit 31 is 1, each write after the first uses the previous id plus 1. When it is 0, every write of the command uses the header id.
- R6: When a command ends on an odd word index inside the buffer, the next word is consumed and discarded. It produces no write.
- R7: The buffer holds `size_units`×2 words. The parser never asserts `word_ready` once that many words have been consumed. It then pulses `done` for one cycle and returns to idle. A size of 0 gives `done` with no word consumed and no write.
- R8: If the buffer ends before all of a command's extra words have arrived, the parser makes no write for the missing words. It sets `trunc_err`, which stays set until the next accepted start, and pulses `done`.
- R9: On an accepted start, `gas_update` latches (`gas_word` == 1) and `flush_req` latches (`flush_word` == 1). A start is accepted only while `busy` is 0.
- R10: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_id`, `wr_data` and `wr_mask` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin parsing a buffer (accepted when idle) |
| size_units | input | SIZE_W | Buffer length in 8-byte units |
| gas_word | input | 32 | Descriptor word for the gas-update flag |
| flush_word | input | 32 | Descriptor word for the flush flag |
| word_valid | input | 1 | Buffer word available |
| word_data | input | 32 | Buffer word |
| word_ready | output | 1 | Parser consumes the word this cycle |
| wr_valid | output | 1 | Register write available |
| wr_id | output | 16 | Target register id |
| wr_data | output | 32 | Write value |
| wr_mask | output | 32 | Byte-enable mask |
| wr_ready | input | 1 | Write accepted |
| busy | output | 1 | Parsing in progress |
| done | output | 1 | One-cycle pulse at the end of a buffer |
| trunc_err | output | 1 | Buffer ended inside a command |
| gas_update | output | 1 | Latched gas-update flag |
| flush_req | output | 1 | Latched flush flag |

## Verification
The word position counter is the state that matters most, because it is never visible at the ports.
- An off-by-one in the position counter or in the parity test shifts which word is taken as a header. Id, mask and data then go wrong on the very next write.
- The same fault can make the parser consume a buffer word that is not there, which shows up as `done` arriving late or never.
- A wrong remaining-count register shows up as a missing or extra write before `done`.
- A stale id register shows up as a repeated or skipped id on the second write of a command.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;
  localparam int WORD_W = 32;
  localparam int ID_W   = 16;
  localparam int MIDX_W = 4;
  localparam int CNT_W  = 8;

  typedef struct packed {
    logic              seq;
    logic [2:0]        unused;
    logic [CNT_W-1:0]  extra;
    logic [MIDX_W-1:0] midx;
    logic [ID_W-1:0]   id;
  } hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BOUND, ST_PAD, ST_PARAM, ST_HDR, ST_EMIT, ST_EXTRA, ST_DONE
  } walk_st_e;
endpackage

// File: rtl/cl_byte_mask.sv
module cl_byte_mask #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]   idx,
  output logic [LANES*8-1:0] mask
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g*8 +: 8] = {8{idx[g]}};
  end
endmodule

// File: rtl/cl_walker.sv
module cl_walker
  import cmdlist_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] size_units,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  output logic              wr_valid,
  output logic [ID_W-1:0]   wr_id,
  output logic [WORD_W-1:0] wr_data,
  output logic [MIDX_W-1:0] wr_midx,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              trunc_err
);
  localparam int POS_W = SIZE_W + 1;

  walk_st_e          st_q, st_n;
  logic [POS_W-1:0]  pos_q, pos_n, total_q, total_n;
  logic [ID_W-1:0]   id_q, id_n;
  logic [WORD_W-1:0] dat_q, dat_n;
  logic [MIDX_W-1:0] midx_q, midx_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              seq_q, seq_n, err_q, err_n;
  logic              at_end, take;
  hdr_t              hdr;

  assign hdr        = hdr_t'(word_data);
  assign at_end     = (pos_q == total_q);
  assign word_ready = (st_q inside {ST_PAD, ST_PARAM, ST_HDR, ST_EXTRA}) && !at_end;
  assign take       = word_ready && word_valid;

  always_comb begin
    st_n = st_q; pos_n = pos_q; total_n = total_q; id_n = id_q;
    dat_n = dat_q; midx_n = midx_q; cnt_n = cnt_q; seq_n = seq_q; err_n = err_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        total_n = {size_units, 1'b0};
        pos_n   = '0;
        err_n   = 1'b0;
        st_n    = ST_BOUND;
      end
      ST_BOUND: begin
        if (at_end)        st_n = ST_DONE;
        else if (pos_q[0]) st_n = ST_PAD;
        else               st_n = ST_PARAM;
      end
      ST_PAD: if (take) begin
        pos_n = pos_q + 1'b1;
        st_n  = ST_BOUND;
      end
      ST_PARAM: if (take) begin
        dat_n = word_data;
        pos_n = pos_q + 1'b1;
        st_n  = ST_HDR;
      end
      ST_HDR: begin
        if (at_end) begin
          err_n = 1'b1;
          st_n  = ST_DONE;
        end else if (take) begin
          id_n   = hdr.id;
          midx_n = hdr.midx;
          cnt_n  = hdr.extra;
          seq_n  = hdr.seq;
          pos_n  = pos_q + 1'b1;
          st_n   = ST_EMIT;
        end
      end
      ST_EMIT: if (wr_ready) begin
        st_n = (cnt_q == '0) ? ST_BOUND : ST_EXTRA;
      end
      ST_EXTRA: begin
        if (at_end) begin
          err_n = 1'b1;
          st_n  = ST_DONE;
        end else if (take) begin
          dat_n = word_data;
          cnt_n = cnt_q - 1'b1;
          id_n  = id_q + ID_W'(seq_q);
          pos_n = pos_q + 1'b1;
          st_n  = ST_EMIT;
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; pos_q <= '0; total_q <= '0; id_q <= '0; dat_q <= '0;
      midx_q <= '0; cnt_q <= '0; seq_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_n; pos_q <= pos_n; total_q <= total_n; id_q <= id_n; dat_q <= dat_n;
      midx_q <= midx_n; cnt_q <= cnt_n; seq_q <= seq_n; err_q <= err_n;
    end
  end

  assign wr_valid  = (st_q == ST_EMIT);
  assign wr_id     = id_q;
  assign wr_data   = dat_q;
  assign wr_midx   = midx_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign trunc_err = err_q;

  p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> busy);
  p_pos_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= total_q);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trunc_err) |-> done);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_id) && $stable(wr_data) && $stable(wr_midx)));
  p_pad_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAD) |-> !wr_valid);
endmodule

// File: rtl/cmdlist_parser.sv
module cmdlist_parser
  import cmdlist_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] size_units,
  input  logic [31:0]       gas_word,
  input  logic [31:0]       flush_word,
  input  logic              word_valid,
  input  logic [31:0]       word_data,
  output logic              word_ready,
  output logic              wr_valid,
  output logic [15:0]       wr_id,
  output logic [31:0]       wr_data,
  output logic [31:0]       wr_mask,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              trunc_err,
  output logic              gas_update,
  output logic              flush_req
);
  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic [MIDX_W-1:0] midx;
  logic              gas_q, flush_q, flag_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  cl_walker #(.SIZE_W(SIZE_W)) i_walk (
    .clk(clk), .rst_n(rst_ni), .start(start), .size_units(size_units),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .wr_valid(wr_valid), .wr_id(wr_id), .wr_data(wr_data), .wr_midx(midx),
    .wr_ready(wr_ready), .busy(busy), .done(done), .trunc_err(trunc_err)
  );

  cl_byte_mask #(.LANES(MIDX_W)) i_mask (.idx(midx), .mask(wr_mask));

  assign flag_en = start && !busy;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      gas_q   <= 1'b0;
      flush_q <= 1'b0;
    end else if (flag_en) begin
      gas_q   <= (gas_word == 32'd1);
      flush_q <= (flush_word == 32'd1);
    end
  end
  assign gas_update = gas_q;
  assign flush_req  = flush_q;

  function automatic logic lanes_ok(input logic [31:0] m);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < 4; b++)
      ok = ok && (m[b*8 +: 8] == 8'h00 || m[b*8 +: 8] == 8'hFF);
    return ok;
  endfunction

  p_mask_lanes_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_valid |-> lanes_ok(wr_mask));
  p_flags_idle_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> ($stable(gas_update) && $stable(flush_req)));
endmodule

// File: tb/test_cmdlist_parser.sv
module test_cmdlist_parser;
  localparam int CLK_P  = 10;
  localparam int SIZE_W = 12;

  // Buffer A: 10 words = size 5; three commands, one padding word at index 9
  localparam logic [31:0] BUF_A [10] = '{
    32'h11111111, 32'h80290040, 32'h22222222, 32'h33333333,
    32'hAAAA0001, 32'h00060123,
    32'hBBBB0002, 32'h001F0200, 32'hCCCC0003, 32'hDEADDEAD };
  localparam logic [15:0] EID_A [6] = '{16'h0040, 16'h0041, 16'h0042, 16'h0123, 16'h0200, 16'h0200};
  localparam logic [31:0] EDT_A [6] = '{32'h11111111, 32'h22222222, 32'h33333333,
                                        32'hAAAA0001, 32'hBBBB0002, 32'hCCCC0003};
  localparam logic [31:0] EMK_A [6] = '{32'hFF0000FF, 32'hFF0000FF, 32'hFF0000FF,
                                        32'h00FFFF00, 32'hFFFFFFFF, 32'hFFFFFFFF};
  // Buffer B: 4 words = size 2; command wants 5 extra words but only 2 exist
  localparam logic [31:0] BUF_B [4] = '{32'h00000005, 32'h80510010, 32'h00000006, 32'h00000007};
  localparam logic [15:0] EID_B [3] = '{16'h0010, 16'h0011, 16'h0012};
  localparam logic [31:0] EDT_B [3] = '{32'h5, 32'h6, 32'h7};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [SIZE_W-1:0] size_units = '0;
  logic [31:0] gas_word = '0, flush_word = '0, word_data = '0;
  logic word_valid = 1'b0, wr_ready = 1'b0;
  logic word_ready, wr_valid, busy, done, trunc_err, gas_update, flush_req;
  logic [15:0] wr_id;
  logic [31:0] wr_data, wr_mask;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] wbuf [16];
  logic [15:0] eid [8];
  logic [31:0] edt [8];
  logic [31:0] emk [8];

  cmdlist_parser #(.SIZE_W(SIZE_W)) i_cmdlist_parser (
    .clk(clk), .rst_n(rst_n), .start(start), .size_units(size_units),
    .gas_word(gas_word), .flush_word(flush_word), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .wr_valid(wr_valid),
    .wr_id(wr_id), .wr_data(wr_data), .wr_mask(wr_mask), .wr_ready(wr_ready),
    .busy(busy), .done(done), .trunc_err(trunc_err),
    .gas_update(gas_update), .flush_req(flush_req));

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic kick(input int sz, input logic [31:0] g, input logic [31:0] f);
    @(negedge clk);
    start = 1'b1; size_units = SIZE_W'(sz); gas_word = g; flush_word = f;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input int nw);
    int i = 0;
    while (i < nw) begin
      @(negedge clk);
      word_valid = 1'b1;
      word_data  = wbuf[i];
      if (word_ready) begin
        @(posedge clk);
        i++;
      end
    end
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic collect(input int ne, input bit stall);
    int k = 0, cyc = 0;
    bit held = 0;
    logic [15:0] hid;
    logic [31:0] hdt, hmk;
    while (k < ne) begin
      @(negedge clk);
      cyc++;
      if (held) begin
        chk(wr_valid && wr_id == hid && wr_data == hdt && wr_mask == hmk,
            "R10 hold under stall", wr_data, hdt);
        held = 0;
      end
      wr_ready = !stall || (cyc % 3 != 0);
      if (wr_valid) begin
        if (wr_ready) begin
          chk(wr_id == eid[k], "R2/R5 id", {16'h0, wr_id}, {16'h0, eid[k]});
          chk(wr_data == edt[k], "R4 data order", wr_data, edt[k]);
          chk(wr_mask == emk[k], "R3 mask", wr_mask, emk[k]);
          k++;
        end else begin
          held = 1; hid = wr_id; hdt = wr_data; hmk = wr_mask;
        end
      end
    end
  endtask

  task automatic finish_wait(input logic exp_err);
    int n = 0;
    wr_ready = 1'b1;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
      if (wr_valid) chk(1'b0, "R8 no extra write", {16'h0, wr_id}, 32'h0);
    end
    chk(done, "R7 done pulse", {31'h0, done}, 32'h1);
    chk(trunc_err == exp_err, "R8 error flag", {31'h0, trunc_err}, {31'h0, exp_err});
    @(negedge clk);
    chk(!busy && !word_ready, "R7 idle after done", {30'h0, busy, word_ready}, 32'h0);
  endtask

  initial begin
    // R1 reset state
    #(CLK_P*2 + 1);
    chk(!wr_valid && !word_ready && !busy && !trunc_err && !gas_update && !flush_req,
        "R1 reset", {26'h0, wr_valid, word_ready, busy, trunc_err, gas_update, flush_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wr_valid && !word_ready && !busy, "R1 after release",
        {29'h0, wr_valid, word_ready, busy}, 32'h0);

    // Table walk: buffer A under backpressure (R2..R6, R10)
    for (int i = 0; i < 10; i++) wbuf[i] = BUF_A[i];
    for (int i = 0; i < 6; i++) begin eid[i] = EID_A[i]; edt[i] = EDT_A[i]; emk[i] = EMK_A[i]; end
    kick(5, 32'd1, 32'd2);
    chk(gas_update && !flush_req, "R9 flags latch", {30'h0, gas_update, flush_req}, 32'h2);
    fork
      feed(10);
      collect(6, 1'b1);
    join
    finish_wait(1'b0);

    // Same table, no stall, opposite flags (R9)
    kick(5, 32'd3, 32'd1);
    chk(!gas_update && flush_req, "R9 flags latch 2", {30'h0, gas_update, flush_req}, 32'h1);
    fork
      feed(10);
      collect(6, 1'b0);
    join
    finish_wait(1'b0);

    // Truncated buffer (R8, R5 consecutive ids, R3 single lane)
    for (int i = 0; i < 4; i++) wbuf[i] = BUF_B[i];
    for (int i = 0; i < 3; i++) begin eid[i] = EID_B[i]; edt[i] = EDT_B[i]; emk[i] = 32'h000000FF; end
    kick(2, 32'd0, 32'd0);
    fork
      feed(4);
      collect(3, 1'b0);
    join
    finish_wait(1'b1);

    // Empty buffer (R7) also clears the error
    kick(0, 32'd0, 32'd0);
    chk(!word_ready, "R7 empty no consume", {31'h0, word_ready}, 32'h0);
    finish_wait(1'b0);

    // Start while busy is ignored (R9): flags stay at the first start's values
    kick(1, 32'd1, 32'd1);
    @(negedge clk);
    start = 1'b1; gas_word = 32'd0; flush_word = 32'd0;
    @(negedge clk);
    start = 1'b0;
    chk(gas_update && flush_req, "R9 start ignored while busy", {30'h0, gas_update, flush_req}, 32'h3);
    wbuf[0] = 32'h0000BEEF; wbuf[1] = 32'h00080007;
    eid[0] = 16'h0007; edt[0] = 32'h0000BEEF; emk[0] = 32'hFF000000;
    fork
      feed(2);
      collect(1, 1'b0);
    join
    finish_wait(1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule